// File: doc/BRIEF.md
# Texture fetch request and result queues

This block sits between one processor and a shared texture sampler. It buffers the coordinates of texture requests on the way out and the colour words on the way back. The processor writes coordinate components one at a time. Writing the s component closes the request, and the t, r and b values written since the previous request are bundled with it. Each closed request takes exactly as many storage slots as it has components, so a queue of eight slots holds anything from two full four-component requests up to eight single-component lookups.

Closed requests go to the sampler in arrival order, as a parallel bundle with a component mask. A request is only released when the result queue can take its whole answer: one word for an 8:8:8:8 colour, or two words for a 16-bit float colour. That count includes answers that are already promised but have not yet come back. The sampler therefore never needs backpressure. The processor pops colour words from a show-ahead read port. Both queues report their occupancy and a full flag. A pop on an empty result queue raises an error strobe. The queues have no notion of threads.

Top module: `tex_fetch_queues`

## Requirements
- R1: After reset both occupancy counts are zero, both full flags are low, `smpValid` is low and `rdErr` is low.
- R2: `reqLevel` counts the component slots in use, including components written but not yet closed by an s write. Writing a t, r or b that is already pending for the open request replaces its value and takes no extra slot.
- R3: While `reqFull` is high, a component write is refused. `reqLevel` does not change and no stored or pending value is altered. The requests already queued later reach the sampler unchanged.
- R4: `reqFull` rises at eight slots. That is four requests of (t, s), or eight s-only requests.
- R5: The component select is 0 = s, 1 = t, 2 = r, 3 = b. A write with select 0 closes the request. The sampler sees `smpMask` with bit i set for each component of select code i that the request carries, the last value written for each, and zero on absent fields.
- R6: Requests reach the sampler strictly in the order they were closed. Colour words are read back in the order the sampler returned them.
- R7: `smpValid` is high only when a request is queued and the result queue can hold its answer. The check counts stored words plus words still owed by the sampler plus the new need (2 when `smpFmt16`, else 1).
- R8: The result queue holds eight words. `resLevel` counts them and `resFull` is high at eight.
- R9: The two words of a float16 answer are read in the order returned: the red/green word first, then the blue/alpha word.
- R10: A pop (`rdEn`) on an empty result queue raises `rdErr` in that cycle and leaves `resLevel` at zero.
- R11: The float16 and direct flags given with the s write travel with the request as `smpFmt16` and `smpDirect`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| compWr | input | 1 | Component write strobe |
| compSel | input | 2 | Component select: 0 s, 1 t, 2 r, 3 b |
| compData | input | DATA_W | Component value |
| compFmt16 | input | 1 | With an s write: answer is two float16 words |
| compDirect | input | 1 | With an s write: direct-address lookup |
| reqFull | output | 1 | Request slots exhausted; writes refused |
| reqLevel | output | clog2(REQ_DEPTH+1) | Request slots in use |
| smpValid | output | 1 | Request offered to the sampler |
| smpReady | input | 1 | Sampler takes the offered request |
| smpMask | output | 4 | Components present, bit index = select code |
| smpS | output | DATA_W | s component |
| smpT | output | DATA_W | t component or zero |
| smpR | output | DATA_W | r component or zero |
| smpB | output | DATA_W | b component or zero |
| smpFmt16 | output | 1 | Request wants a two-word float16 answer |
| smpDirect | output | 1 | Request is a direct-address lookup |
| rspValid | input | 1 | Sampler colour word valid |
| rspData | input | DATA_W | Sampler colour word |
| rdEn | input | 1 | Pop the head colour word |
| rdData | output | DATA_W | Head colour word (show-ahead) |
| rdErr | output | 1 | Pop attempted on an empty result queue |
| resFull | output | 1 | Result queue holds eight words |
| resLevel | output | clog2(RES_DEPTH+1) | Result words stored |

## Verification
The hardest case to reach from the ports is the release gate refusing a request while the result queue is nearly full. The stimulus withholds reads and stacks four float16 requests until the result queue is full. It then closes a fifth float16 request and pops one word at a time. The request must stay held at seven stored words and be released at six. Refused writes are checked after the fact by draining the request queue into a responder that compares every bundle against the bench's own grouping model.

// File: rtl/tex_fetch_pkg.sv
package tex_fetch_pkg;

  localparam logic [1:0] SEL_S = 2'd0;
  localparam logic [1:0] SEL_T = 2'd1;
  localparam logic [1:0] SEL_R = 2'd2;
  localparam logic [1:0] SEL_B = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       pendWr;      // latch a t/r/b into the open request
    logic       commit;      // close the open request with s
    logic [3:0] commitMask;  // components in the closing request, bit = select code
    logic       dispatch;    // head request taken by the sampler
    logic       rspPush;     // store a colour word
    logic       resPop;      // drop the head colour word
  } tex_stb_t;

  // one queued request descriptor
  typedef struct packed {
    logic       direct;
    logic       fmt16;
    logic [3:0] mask;
  } tex_desc_t;

  // slot order inside a request: t, r, b, then s
  function automatic logic [1:0] slotComp(input int k);
    return (k == 3) ? SEL_S : 2'(k + 1);
  endfunction

endpackage

// File: rtl/tex_fetch_ctrl.sv
module tex_fetch_ctrl
  import tex_fetch_pkg::*;
#(
  parameter int REQ_DEPTH = 8,
  parameter int RES_DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           compWr,
  input  logic [1:0]                     compSel,
  input  logic [3:0]                     headMask,
  input  logic                           headFmt16,
  input  logic                           smpReady,
  input  logic                           rspValid,
  input  logic                           rdEn,
  output tex_stb_t                       stb,
  output logic                           reqFull,
  output logic [$clog2(REQ_DEPTH+1)-1:0] reqLevel,
  output logic                           smpValid,
  output logic                           rdErr,
  output logic                           resFull,
  output logic [$clog2(RES_DEPTH+1)-1:0] resLevel
);

  localparam int RQ_CW = $clog2(REQ_DEPTH + 1);
  localparam int RS_CW = $clog2(RES_DEPTH + 1);

  logic [RQ_CW-1:0] slotCnt;   // slots held by closed requests
  logic [RQ_CW-1:0] descCnt;   // closed requests waiting
  logic [2:0]       pendMask;  // open request: bit0 t, bit1 r, bit2 b
  logic [RS_CW-1:0] resCnt;    // colour words stored
  logic [RS_CW-1:0] resRsv;    // colour words owed by the sampler

  logic [RQ_CW-1:0] pendNum, headNum, usedNow;
  logic [RS_CW:0]   resNeed, resProj;
  logic             accept, isS;

  always_comb begin
    pendNum = RQ_CW'(pendMask[0]) + RQ_CW'(pendMask[1]) + RQ_CW'(pendMask[2]);
    headNum = RQ_CW'(headMask[0]) + RQ_CW'(headMask[1]) +
              RQ_CW'(headMask[2]) + RQ_CW'(headMask[3]);
    usedNow = slotCnt + pendNum;
    reqFull = (usedNow == RQ_CW'(REQ_DEPTH));
    accept  = compWr && !reqFull;
    isS     = (compSel == SEL_S);
    resNeed = headFmt16 ? (RS_CW+1)'(2) : (RS_CW+1)'(1);
    resProj = {1'b0, resCnt} + {1'b0, resRsv} + resNeed;
    smpValid = (descCnt != '0) && (resProj <= (RS_CW+1)'(RES_DEPTH));

    stb.pendWr     = accept && !isS;
    stb.commit     = accept && isS;
    stb.commitMask = {pendMask, 1'b1};
    stb.dispatch   = smpValid && smpReady;
    stb.rspPush    = rspValid;
    stb.resPop     = rdEn && (resCnt != '0);

    rdErr    = rdEn && (resCnt == '0);
    resFull  = (resCnt == RS_CW'(RES_DEPTH));
    reqLevel = usedNow;
    resLevel = resCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt  <= '0;
      descCnt  <= '0;
      pendMask <= '0;
      resCnt   <= '0;
      resRsv   <= '0;
    end else begin
      slotCnt <= slotCnt + (stb.commit ? pendNum + RQ_CW'(1) : '0)
                         - (stb.dispatch ? headNum : '0);
      descCnt <= descCnt + RQ_CW'(stb.commit) - RQ_CW'(stb.dispatch);
      if (stb.commit)
        pendMask <= '0;
      else if (stb.pendWr)
        pendMask[compSel - 2'd1] <= 1'b1;
      resRsv <= resRsv + (stb.dispatch ? resNeed[RS_CW-1:0] : '0)
                       - RS_CW'(stb.rspPush);
      resCnt <= resCnt + RS_CW'(stb.rspPush) - RS_CW'(stb.resPop);
    end
  end

  AST_REFUSED_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    compWr && reqFull && !stb.dispatch |=> reqLevel == $past(reqLevel)); // R3

  AST_REQ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    reqLevel <= RQ_CW'(REQ_DEPTH)); // R4

  AST_RSP_OWED: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> resRsv != '0); // R7

  AST_DISPATCH_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    stb.dispatch |=> ({1'b0, resCnt} + {1'b0, resRsv}) <= (RS_CW+1)'(RES_DEPTH)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> resCnt != RS_CW'(RES_DEPTH)); // R8

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |=> resLevel == RS_CW'($past(rspValid))); // R10

endmodule

// File: rtl/tex_fetch_dpath.sv
module tex_fetch_dpath
  import tex_fetch_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REQ_DEPTH = 8,
  parameter int RES_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tex_stb_t          stb,
  input  logic [1:0]        compSel,
  input  logic [DATA_W-1:0] compData,
  input  logic              compFmt16,
  input  logic              compDirect,
  input  logic [DATA_W-1:0] rspData,
  output logic [3:0]        headMask,
  output logic              headFmt16,
  output logic              headDirect,
  output logic [DATA_W-1:0] headS,
  output logic [DATA_W-1:0] headT,
  output logic [DATA_W-1:0] headR,
  output logic [DATA_W-1:0] headB,
  output logic [DATA_W-1:0] rdData
);

  localparam int QP_W = $clog2(REQ_DEPTH);
  localparam int RP_W = $clog2(RES_DEPTH);

  logic [DATA_W-1:0] slotMem [REQ_DEPTH];
  tex_desc_t         descMem [REQ_DEPTH];
  logic [DATA_W-1:0] resMem  [RES_DEPTH];
  logic [DATA_W-1:0] pendData [3];

  logic [QP_W-1:0] slotWr, slotRd, descWr, descRd;
  logic [RP_W-1:0] resWr, resRd;

  logic [QP_W-1:0]   wrOff [4];
  logic [QP_W-1:0]   rdOff [4];
  logic [DATA_W-1:0] compVal [4];
  logic [DATA_W-1:0] headVal [4];
  tex_desc_t         headDesc;

  always_comb begin
    logic [QP_W-1:0] wAcc, rAcc;
    headDesc = descMem[descRd];
    wAcc = '0;
    rAcc = '0;
    compVal[0] = compData;
    for (int c = 1; c < 4; c++) compVal[c] = pendData[c-1];
    for (int k = 0; k < 4; k++) begin
      wrOff[k] = wAcc;
      rdOff[k] = rAcc;
      if (stb.commitMask[slotComp(k)]) wAcc = wAcc + QP_W'(1);
      if (headDesc.mask[slotComp(k)])  rAcc = rAcc + QP_W'(1);
    end
    for (int k = 0; k < 4; k++)
      headVal[slotComp(k)] = headDesc.mask[slotComp(k)] ?
                             slotMem[slotRd + rdOff[k]] : '0;
  end

  assign headMask   = headDesc.mask;
  assign headFmt16  = headDesc.fmt16;
  assign headDirect = headDesc.direct;
  assign headS      = headVal[0];
  assign headT      = headVal[1];
  assign headR      = headVal[2];
  assign headB      = headVal[3];
  assign rdData     = resMem[resRd];

  // open request components and closed slot storage
  always_ff @(posedge clk) begin
    if (stb.pendWr) pendData[compSel - 2'd1] <= compData;
    if (stb.commit) begin
      for (int k = 0; k < 4; k++)
        if (stb.commitMask[slotComp(k)])
          slotMem[slotWr + wrOff[k]] <= compVal[slotComp(k)];
      descMem[descWr] <= '{direct: compDirect, fmt16: compFmt16,
                           mask: stb.commitMask};
    end
    if (stb.rspPush) resMem[resWr] <= rspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotWr <= '0;
      slotRd <= '0;
      descWr <= '0;
      descRd <= '0;
      resWr  <= '0;
      resRd  <= '0;
    end else begin
      if (stb.commit) begin
        slotWr <= slotWr + wrOff[3] + QP_W'(1);
        descWr <= descWr + QP_W'(1);
      end
      if (stb.dispatch) begin
        slotRd <= slotRd + rdOff[3] + QP_W'(1);
        descRd <= descRd + QP_W'(1);
      end
      if (stb.rspPush) resWr <= resWr + RP_W'(1);
      if (stb.resPop)  resRd <= resRd + RP_W'(1);
    end
  end

  AST_HEAD_HAS_S: assert property (@(posedge clk) disable iff (!rstN)
    stb.dispatch |-> headMask[0]); // R5

  AST_COMMIT_CLOSES_WITH_S: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |-> compSel == SEL_S); // R5

endmodule

// File: rtl/tex_fetch_queues.sv
module tex_fetch_queues
  import tex_fetch_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REQ_DEPTH = 8,
  parameter int RES_DEPTH = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           compWr,
  input  logic [1:0]                     compSel,
  input  logic [DATA_W-1:0]              compData,
  input  logic                           compFmt16,
  input  logic                           compDirect,
  output logic                           reqFull,
  output logic [$clog2(REQ_DEPTH+1)-1:0] reqLevel,
  output logic                           smpValid,
  input  logic                           smpReady,
  output logic [3:0]                     smpMask,
  output logic [DATA_W-1:0]              smpS,
  output logic [DATA_W-1:0]              smpT,
  output logic [DATA_W-1:0]              smpR,
  output logic [DATA_W-1:0]              smpB,
  output logic                           smpFmt16,
  output logic                           smpDirect,
  input  logic                           rspValid,
  input  logic [DATA_W-1:0]              rspData,
  input  logic                           rdEn,
  output logic [DATA_W-1:0]              rdData,
  output logic                           rdErr,
  output logic                           resFull,
  output logic [$clog2(RES_DEPTH+1)-1:0] resLevel
);

  tex_stb_t stb;

  tex_fetch_ctrl #(.REQ_DEPTH(REQ_DEPTH), .RES_DEPTH(RES_DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .compWr(compWr), .compSel(compSel),
    .headMask(smpMask), .headFmt16(smpFmt16), .smpReady(smpReady),
    .rspValid(rspValid), .rdEn(rdEn), .stb(stb), .reqFull(reqFull),
    .reqLevel(reqLevel), .smpValid(smpValid), .rdErr(rdErr),
    .resFull(resFull), .resLevel(resLevel)
  );

  tex_fetch_dpath #(.DATA_W(DATA_W), .REQ_DEPTH(REQ_DEPTH),
                    .RES_DEPTH(RES_DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .compSel(compSel),
    .compData(compData), .compFmt16(compFmt16), .compDirect(compDirect),
    .rspData(rspData), .headMask(smpMask), .headFmt16(smpFmt16),
    .headDirect(smpDirect), .headS(smpS), .headT(smpT), .headR(smpR),
    .headB(smpB), .rdData(rdData)
  );

endmodule

// File: tb/tex_fetch_queues_tb.sv
`timescale 1ns/1ps
module tex_fetch_queues_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        compWr = 0, compFmt16 = 0, compDirect = 0;
  logic [1:0]  compSel = 0;
  logic [31:0] compData = 0;
  logic        smpReady = 0, rspValid = 0, rdEn = 0;
  logic [31:0] rspData = 0;
  logic        reqFull, smpValid, smpFmt16, smpDirect, rdErr, resFull;
  logic [3:0]  reqLevel, resLevel, smpMask;
  logic [31:0] smpS, smpT, smpR, smpB, rdData;

  tex_fetch_queues dut_i (
    .clk(clk), .rstN(rstN), .compWr(compWr), .compSel(compSel),
    .compData(compData), .compFmt16(compFmt16), .compDirect(compDirect),
    .reqFull(reqFull), .reqLevel(reqLevel), .smpValid(smpValid),
    .smpReady(smpReady), .smpMask(smpMask), .smpS(smpS), .smpT(smpT),
    .smpR(smpR), .smpB(smpB), .smpFmt16(smpFmt16), .smpDirect(smpDirect),
    .rspValid(rspValid), .rspData(rspData), .rdEn(rdEn), .rdData(rdData),
    .rdErr(rdErr), .resFull(resFull), .resLevel(resLevel)
  );

  always #10 clk = ~clk;

  int nChk = 0, nFail = 0;

  // expected requests: {fmt, direct, mask, s, t, r, b}
  logic [133:0] expReq [64];
  int expReqHd = 0, expReqTl = 0;
  logic [31:0] expRes [64];
  int expResHd = 0, expResTl = 0;
  logic [31:0] rspBuf [64];
  int rspHd = 0, rspTl = 0;
  // bench model of the open request
  logic [31:0] mT, mR, mB;
  logic [2:0]  mMask;

  // table: {sel, fmt16, direct, data}
  localparam int NVEC = 14;
  localparam logic [35:0] VEC [NVEC] = '{
    {2'd1, 1'b0, 1'b0, 32'h0000_0100}, {2'd0, 1'b0, 1'b0, 32'h0000_0001},
    {2'd0, 1'b0, 1'b1, 32'h0000_0002}, {2'd2, 1'b0, 1'b0, 32'h0000_0300},
    {2'd3, 1'b0, 1'b0, 32'h0000_0400}, {2'd1, 1'b0, 1'b0, 32'h0000_0200},
    {2'd0, 1'b1, 1'b0, 32'h0000_0003}, {2'd0, 1'b1, 1'b0, 32'h0000_0004},
    {2'd1, 1'b0, 1'b0, 32'h0000_0500}, {2'd0, 1'b0, 1'b0, 32'h0000_0005},
    {2'd3, 1'b0, 1'b0, 32'h0000_0600}, {2'd0, 1'b0, 1'b1, 32'h0000_0006},
    {2'd2, 1'b0, 1'b0, 32'h0000_0800}, {2'd0, 1'b1, 1'b0, 32'h0000_0008}
  };

  task automatic chk(input logic ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] colour(input logic [31:0] s, input logic [31:0] t,
                                          input logic f16, input int beat);
    if (!f16) return {8'hC0, s[7:0] ^ t[7:0], s[15:8], 8'h01};
    return (beat == 0) ? {16'h4752, s[15:0]} : {16'h4241, s[15:0] ^ t[15:0]};
  endfunction

  // one clock: check handshakes and pops, then run the responder
  task automatic tick();
    logic hs;
    logic [133:0] got;
    #1;
    hs = smpValid && smpReady;
    if (hs) begin
      got = {smpFmt16, smpDirect, smpMask, smpS, smpT, smpR, smpB};
      if (expReqHd < expReqTl) begin
        chk(got == expReq[expReqHd], "R5 R6 R11 request bundle",
            got[31:0] ^ got[127:96], expReq[expReqHd][31:0] ^ expReq[expReqHd][127:96]);
        chk(got[133:128] == expReq[expReqHd][133:128], "R11 flags and mask",
            32'(got[133:128]), 32'(expReq[expReqHd][133:128]));
        expReqHd++;
      end else chk(1'b0, "R6 unexpected request", 32'(smpMask), 0);
      for (int b = 0; b < (smpFmt16 ? 2 : 1); b++) begin
        rspBuf[rspTl] = colour(smpS, smpT, smpFmt16, b);
        expRes[expResTl] = rspBuf[rspTl];
        rspTl++; expResTl++;
      end
    end
    if (rdEn && resLevel != 0) begin
      if (expResHd < expResTl) begin
        chk(rdData == expRes[expResHd], "R9 colour word order", rdData, expRes[expResHd]);
        expResHd++;
      end else chk(1'b0, "R6 unexpected colour word", rdData, 0);
    end
    @(posedge clk);
    #1;
    if (rspValid) rspHd++;
    rspValid = (rspHd < rspTl);
    rspData  = rspValid ? rspBuf[rspHd] : '0;
  endtask

  task automatic writeComp(input logic [1:0] sel, input logic [31:0] d,
                           input logic f16, input logic dir, output logic acc);
    acc = !reqFull;
    compWr = 1; compSel = sel; compData = d; compFmt16 = f16; compDirect = dir;
    if (acc) begin
      case (sel)
        2'd1: begin mT = d; mMask[0] = 1'b1; end
        2'd2: begin mR = d; mMask[1] = 1'b1; end
        2'd3: begin mB = d; mMask[2] = 1'b1; end
        default: begin
          expReq[expReqTl] = {f16, dir, mMask, 1'b1, d,
                              mMask[0] ? mT : 32'h0, mMask[1] ? mR : 32'h0,
                              mMask[2] ? mB : 32'h0};
          expReqTl++;
          mMask = '0;
        end
      endcase
    end
    tick();
    compWr = 0;
  endtask

  task automatic doReset();
    rstN = 0; compWr = 0; rdEn = 0; smpReady = 0; rspValid = 0;
    expReqHd = 0; expReqTl = 0; expResHd = 0; expResTl = 0;
    rspHd = 0; rspTl = 0; mMask = '0;
    repeat (3) @(posedge clk);
    #1; rstN = 1;
  endtask

  task automatic drain();
    smpReady = 1;
    for (int i = 0; i < 400; i++) begin
      if (expReqHd == expReqTl && expResHd == expResTl && rspHd == rspTl) break;
      rdEn = (resLevel != 0);
      tick();
    end
    rdEn = 0;
    chk(expReqHd == expReqTl, "R6 all requests dispatched", 32'(expReqHd), 32'(expReqTl));
    chk(expResHd == expResTl, "R6 all colour words read", 32'(expResHd), 32'(expResTl));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic acc;
    doReset();
    // R1 reset state
    chk(reqLevel == 0, "R1 reqLevel", 32'(reqLevel), 0);
    chk(resLevel == 0, "R1 resLevel", 32'(resLevel), 0);
    chk(!reqFull && !resFull, "R1 full flags", 32'({reqFull, resFull}), 0);
    chk(!smpValid, "R1 smpValid", 32'(smpValid), 0);
    chk(!rdErr, "R1 rdErr", 32'(rdErr), 0);

    // table walk with slow reads
    smpReady = 1;
    for (int i = 0; i < NVEC; i++) begin
      int tries = 0;
      do begin
        rdEn = (i % 2 == 1) && (resLevel != 0);
        writeComp(VEC[i][35:34], VEC[i][31:0], VEC[i][33], VEC[i][32], acc);
        rdEn = 0;
        tries++;
      end while (!acc && tries < 50);
    end
    drain();

    // R2 slot counting and rewrite of a pending component
    doReset();
    writeComp(2'd1, 32'h11, 0, 0, acc);
    chk(reqLevel == 1, "R2 level after t", 32'(reqLevel), 1);
    writeComp(2'd1, 32'h22, 0, 0, acc);
    chk(reqLevel == 1, "R2 rewrite of t takes no slot", 32'(reqLevel), 1);
    writeComp(2'd2, 32'h33, 0, 0, acc);
    writeComp(2'd0, 32'h44, 0, 0, acc);
    chk(reqLevel == 3, "R2 level after s closes", 32'(reqLevel), 3);
    chk(smpValid && smpMask == 4'b0111, "R5 mask s t r", 32'(smpMask), 32'h7);
    chk(smpT == 32'h22 && smpB == 0, "R2 last t value, R5 absent b zero", smpT, 32'h22);
    drain();
    chk(reqLevel == 0, "R2 level after dispatch", 32'(reqLevel), 0);

    // R3 R4 capacity with (t, s) requests
    doReset();
    for (int i = 0; i < 4; i++) begin
      writeComp(2'd1, 32'hA0 + 32'(i), 0, 0, acc);
      writeComp(2'd0, 32'hB0 + 32'(i), 0, 0, acc);
    end
    chk(reqLevel == 8 && reqFull, "R4 four (t,s) requests fill", 32'(reqLevel), 8);
    writeComp(2'd0, 32'hDEAD, 0, 0, acc);
    chk(!acc && reqLevel == 8, "R3 write refused when full", 32'(reqLevel), 8);
    drain();

    // R3 R4 capacity with s-only direct requests
    doReset();
    for (int i = 0; i < 8; i++) writeComp(2'd0, 32'hC0 + 32'(i), 0, 1, acc);
    chk(reqLevel == 8 && reqFull, "R4 eight s-only requests fill", 32'(reqLevel), 8);
    writeComp(2'd1, 32'hBEEF, 0, 0, acc);
    chk(!acc && reqLevel == 8, "R3 pending write refused when full", 32'(reqLevel), 8);
    drain();
    writeComp(2'd0, 32'h77, 0, 0, acc);
    chk(smpMask == 4'b0001, "R3 refused t left no trace", 32'(smpMask), 1);
    drain();

    // R7 R8 release gate against result room
    doReset();
    smpReady = 1;
    for (int i = 0; i < 4; i++) writeComp(2'd0, 32'h900 + 32'(i), 1, 0, acc);
    repeat (10) tick();
    chk(resLevel == 8 && resFull, "R8 result queue full", 32'(resLevel), 8);
    writeComp(2'd0, 32'h9FF, 1, 0, acc);
    chk(!smpValid, "R7 held with no room", 32'(smpValid), 0);
    rdEn = 1; tick(); rdEn = 0;
    chk(resLevel == 7 && !smpValid, "R7 one free slot not enough for float16",
        32'(smpValid), 0);
    rdEn = 1; tick(); rdEn = 0;
    chk(resLevel == 6 && smpValid, "R7 released with two free slots", 32'(smpValid), 1);
    drain();

    // R10 pop on empty
    doReset();
    rdEn = 1;
    #1;
    chk(rdErr, "R10 rdErr on empty pop", 32'(rdErr), 1);
    tick();
    rdEn = 0;
    #1;
    chk(resLevel == 0 && !rdErr, "R10 level stays zero", 32'(resLevel), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule